// File: doc/BRIEF.md
# Ethernet MII Transmit Framer

This block turns frames from a byte-wide application stream into nibble traffic on a 4-bit MII transmit interface. It runs on the MII transmit clock and sends one nibble per cycle, so the same logic works at 10 and at 100 Mbit/s. The application supplies only the payload, starting at the destination address. The framer adds the preamble and the start-of-frame delimiter in front of it. If the frame asks for it, the framer also pads the payload with zero octets and appends the 32-bit frame check sequence. Padding and the check sequence are selected per frame by two sideband bits that travel with the first byte.

Between frames the framer holds the transmit enable low for a gap that software can set in steps of 8 bit times. In full-duplex operation a flow-control request input starts a pause frame when it rises. When the request falls, the framer sends a second pause frame whose pause time is zero. A pending pause frame goes out at the next frame boundary, ahead of any application frame that is already waiting.

Top module: `mii_tx_framer`

## Requirements
- R1: Every frame starts with seven 0x55 octets and one 0xD5 octet. Each octet goes out low nibble first on `mii_txd`. `mii_tx_en` stays high for the whole frame, and `mii_txd` is 0 whenever `mii_tx_en` is low.
- R2: After the start delimiter, the application bytes go out in the order they were accepted, each one exactly once.
- R3: When `app_pad_en` is 1 on the first byte and the payload is shorter than 60 octets, zero octets are appended until the payload reaches 60 octets. A payload of 60 octets or more is left as it is.
- R4: When `app_pad_en` is 0, a short payload is sent without any padding.
- R5: When `app_crc_en` is 1 on the first byte, four check octets follow the payload and padding. They hold the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, result inverted), least significant octet first. When `app_crc_en` is 0, no check octets are sent.
- R6: When frames follow each other back to back, `mii_tx_en` is low for exactly 10 + 2*`ifg_sel` clock cycles between them. This equals 40 + 8*`ifg_sel` bit times.
- R7: While `full_duplex` is 1, a rising edge on `fc_req` queues a pause frame. Its payload is 01 80 C2 00 00 01, then `station_mac` with the most significant octet first, then 88 08, then 00 01, then `pause_time` with the high octet first. The frame is padded to 60 octets and closed with the check sequence.
- R8: While `full_duplex` is 1, a falling edge on `fc_req` queues a pause frame of the same layout with a pause time of 0000.
- R9: A queued pause frame goes out after the gap that follows the current frame. It goes ahead of an application frame that is already waiting, and that application frame follows after a further gap.
- R10: While `full_duplex` is 0, edges on `fc_req` queue no pause frame. No pause frame appears later when `full_duplex` returns to 1.
- R11: While reset is asserted, `mii_tx_en` is 0, `mii_txd` is 0 and `app_ready` is 0.
- R12: `app_ready` is high for single cycles only, never in two consecutive cycles, and only while `mii_tx_en` is high. Each high cycle takes the byte on `app_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII transmit clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| app_valid | input | 1 | Application byte present |
| app_data | input | 8 | Application byte |
| app_sof | input | 1 | Marks the first byte of a frame |
| app_eof | input | 1 | Marks the last byte of a frame |
| app_pad_en | input | 1 | Pad request, sampled with the first byte |
| app_crc_en | input | 1 | Check-sequence request, sampled with the first byte |
| app_ready | output | 1 | Byte accepted at this clock edge |
| full_duplex | input | 1 | Full-duplex mode; enables pause generation |
| fc_req | input | 1 | Flow-control request level |
| pause_time | input | 16 | Pause time placed in pause frames sent on a rising edge |
| station_mac | input | 48 | Source address placed in pause frames |
| ifg_sel | input | 3 | Gap setting: 40 + 8*value bit times |
| mii_txd | output | 4 | MII transmit nibble |
| mii_tx_en | output | 1 | MII transmit enable |

## Verification
The assertions assume the application never underruns a frame. Once it has offered a first byte, a valid byte must be on `app_data` every time `app_ready` is high, up to and including the byte marked as last. Under that assumption, the nibble sequence and the `app_ready` rhythm depend only on the framer's own counters. The stimulus keeps to this rule by putting the next byte on the bus at the falling edge that follows each accepted byte. It also changes `ifg_sel`, `full_duplex` and `fc_req` only at falling edges, never in the same cycle as a clock edge.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

    localparam int FRAME_CNT_W = 16;

    localparam logic [7:0]  OCT_PRE  = 8'h55;
    localparam logic [7:0]  OCT_SFD  = 8'hD5;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_IFG
    } tx_state_e;

    typedef struct packed {
        tx_state_e              state;
        logic                   nib;
        logic [FRAME_CNT_W-1:0] cnt;
        logic [7:0]             oct;
        logic                   last;
        logic                   pause_frm;
        logic                   zero_frm;
        logic                   pad_en;
        logic                   crc_en;
        logic                   pend;
        logic                   pend_zero;
        logic                   fc_q;
    } tx_regs_t;

    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
    import mii_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q_o,
    output logic [31:0] crc_nxt_o
);

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_nxt_o = crc32_byte(crc_q, din);
        crc_d     = crc_q;
        if (clr) begin
            crc_d = '1;
        end else if (en) begin
            crc_d = crc_nxt_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_q_o = crc_q;

endmodule

// File: rtl/mii_tx_pause_src.sv
module mii_tx_pause_src #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [47:0]      mac,
    input  logic [15:0]      quanta,
    output logic [7:0]       oct
);

    always_comb begin
        case (idx)
            IDX_W'(0):  oct = 8'h01;
            IDX_W'(1):  oct = 8'h80;
            IDX_W'(2):  oct = 8'hC2;
            IDX_W'(3):  oct = 8'h00;
            IDX_W'(4):  oct = 8'h00;
            IDX_W'(5):  oct = 8'h01;
            IDX_W'(6):  oct = mac[47:40];
            IDX_W'(7):  oct = mac[39:32];
            IDX_W'(8):  oct = mac[31:24];
            IDX_W'(9):  oct = mac[23:16];
            IDX_W'(10): oct = mac[15:8];
            IDX_W'(11): oct = mac[7:0];
            IDX_W'(12): oct = 8'h88;
            IDX_W'(13): oct = 8'h08;
            IDX_W'(14): oct = 8'h00;
            IDX_W'(15): oct = 8'h01;
            IDX_W'(16): oct = quanta[15:8];
            IDX_W'(17): oct = quanta[7:0];
            default:    oct = 8'h00;
        endcase
    end

endmodule

// File: rtl/mii_tx_ifg.sv
module mii_tx_ifg #(
    parameter int BASE_NIB = 10,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        // gap minus two: one idle cycle and the final count cycle close the gap
        lim   = CNT_W'(BASE_NIB - 2) + CNT_W'({sel, 1'b0});
        done  = run && (cnt_q == lim);
        cnt_d = run ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
    import mii_tx_pkg::*;
#(
    parameter int MIN_OCTETS   = 60,
    parameter int PRE_OCTETS   = 7,
    parameter int IFG_BASE_NIB = 10,
    parameter int IFG_SEL_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 app_valid,
    input  logic [7:0]           app_data,
    input  logic                 app_sof,
    input  logic                 app_eof,
    input  logic                 app_pad_en,
    input  logic                 app_crc_en,
    output logic                 app_ready,
    input  logic                 full_duplex,
    input  logic                 fc_req,
    input  logic [15:0]          pause_time,
    input  logic [47:0]          station_mac,
    input  logic [IFG_SEL_W-1:0] ifg_sel,
    output logic [3:0]           mii_txd,
    output logic                 mii_tx_en
);

    localparam int PAUSE_IDX_W = 5;
    localparam int PAUSE_LEN   = 18;
    localparam logic [FRAME_CNT_W-1:0] MIN_C      = FRAME_CNT_W'(MIN_OCTETS);
    localparam logic [FRAME_CNT_W-1:0] PRE_C      = FRAME_CNT_W'(PRE_OCTETS);
    localparam logic [FRAME_CNT_W-1:0] PAUSE_LAST = FRAME_CNT_W'(PAUSE_LEN - 1);
    localparam logic [FRAME_CNT_W-1:0] FCS_LAST   = FRAME_CNT_W'(3);

    tx_regs_t r_d, r_q;

    logic                   crc_clr, crc_upd;
    logic [31:0]            crc_q, crc_nxt;
    logic [PAUSE_IDX_W-1:0] pause_idx;
    logic [7:0]             pause_oct;
    logic [15:0]            pause_q16;
    logic                   ifg_done;
    logic [FRAME_CNT_W-1:0] cnt_inc;
    logic [1:0]             fcs_idx;
    logic [31:0]            fcs_sh;
    logic                   fc_rise, fc_fall, take_pause;

    mii_tx_crc u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (crc_clr),
        .en        (crc_upd),
        .din       (r_q.oct),
        .crc_q_o   (crc_q),
        .crc_nxt_o (crc_nxt)
    );

    mii_tx_pause_src #(.IDX_W(PAUSE_IDX_W)) u_pause (
        .idx    (pause_idx),
        .mac    (station_mac),
        .quanta (pause_q16),
        .oct    (pause_oct)
    );

    mii_tx_ifg #(
        .BASE_NIB (IFG_BASE_NIB),
        .SEL_W    (IFG_SEL_W),
        .CNT_W    (8)
    ) u_ifg (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == ST_IDLE ? 1'b0 : (r_q.state == ST_IFG)),
        .sel   (ifg_sel),
        .done  (ifg_done)
    );

    always_comb begin
        r_d       = r_q;
        app_ready = 1'b0;
        crc_clr   = 1'b0;
        crc_upd   = 1'b0;

        cnt_inc   = r_q.cnt + 1'b1;
        pause_idx = (r_q.state == ST_DATA) ? cnt_inc[PAUSE_IDX_W-1:0] : '0;
        pause_q16 = r_q.zero_frm ? 16'h0000 : pause_time;
        fcs_idx   = r_q.cnt[1:0] + 2'd1;
        fcs_sh    = crc_q >> {fcs_idx, 3'b000};

        fc_rise    = fc_req && !r_q.fc_q;
        fc_fall    = !fc_req && r_q.fc_q;
        take_pause = (r_q.state == ST_IDLE) && r_q.pend && full_duplex;

        // flow-control edge tracking, always sampled so no stale edge remains
        r_d.fc_q = fc_req;
        if (!full_duplex) begin
            r_d.pend = 1'b0;
        end else if (fc_rise || fc_fall) begin
            r_d.pend      = 1'b1;
            r_d.pend_zero = fc_fall;
        end else if (take_pause) begin
            r_d.pend = 1'b0;
        end

        case (r_q.state)
            ST_IDLE: begin
                crc_clr = 1'b1;
                r_d.nib = 1'b0;
                r_d.cnt = '0;
                r_d.oct = OCT_PRE;
                if (take_pause) begin
                    r_d.state     = ST_PRE;
                    r_d.pause_frm = 1'b1;
                    r_d.zero_frm  = r_q.pend_zero;
                    r_d.pad_en    = 1'b1;
                    r_d.crc_en    = 1'b1;
                end else if (app_valid && app_sof) begin
                    r_d.state     = ST_PRE;
                    r_d.pause_frm = 1'b0;
                    r_d.pad_en    = app_pad_en;
                    r_d.crc_en    = app_crc_en;
                end
            end

            ST_PRE: begin
                r_d.nib = ~r_q.nib;
                if (r_q.nib) begin
                    if (r_q.cnt == PRE_C) begin
                        r_d.state = ST_DATA;
                        r_d.cnt   = '0;
                        if (r_q.pause_frm) begin
                            r_d.oct  = pause_oct;
                            r_d.last = 1'b0;
                        end else begin
                            r_d.oct   = app_data;
                            r_d.last  = app_eof;
                            app_ready = 1'b1;
                        end
                    end else begin
                        r_d.cnt = cnt_inc;
                        r_d.oct = (cnt_inc == PRE_C) ? OCT_SFD : OCT_PRE;
                    end
                end
            end

            ST_DATA: begin
                r_d.nib = ~r_q.nib;
                if (r_q.nib) begin
                    crc_upd = 1'b1;
                    if (!r_q.last) begin
                        r_d.cnt = cnt_inc;
                        if (r_q.pause_frm) begin
                            r_d.oct  = pause_oct;
                            r_d.last = (cnt_inc == PAUSE_LAST);
                        end else begin
                            r_d.oct   = app_data;
                            r_d.last  = app_eof;
                            app_ready = 1'b1;
                        end
                    end else if (r_q.pad_en && (cnt_inc < MIN_C)) begin
                        r_d.state = ST_PAD;
                        r_d.cnt   = cnt_inc;
                        r_d.oct   = 8'h00;
                    end else if (r_q.crc_en) begin
                        r_d.state = ST_FCS;
                        r_d.cnt   = '0;
                        r_d.oct   = ~crc_nxt[7:0];
                    end else begin
                        r_d.state = ST_IFG;
                    end
                end
            end

            ST_PAD: begin
                r_d.nib = ~r_q.nib;
                if (r_q.nib) begin
                    crc_upd = 1'b1;
                    if (cnt_inc < MIN_C) begin
                        r_d.cnt = cnt_inc;
                        r_d.oct = 8'h00;
                    end else if (r_q.crc_en) begin
                        r_d.state = ST_FCS;
                        r_d.cnt   = '0;
                        r_d.oct   = ~crc_nxt[7:0];
                    end else begin
                        r_d.state = ST_IFG;
                    end
                end
            end

            ST_FCS: begin
                r_d.nib = ~r_q.nib;
                if (r_q.nib) begin
                    if (r_q.cnt == FCS_LAST) begin
                        r_d.state = ST_IFG;
                    end else begin
                        r_d.cnt = cnt_inc;
                        r_d.oct = ~fcs_sh[7:0];
                    end
                end
            end

            ST_IFG: begin
                r_d.nib = 1'b0;
                if (ifg_done) begin
                    r_d.state = ST_IDLE;
                end
            end

            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= ST_IDLE;
            r_q.oct       <= OCT_PRE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mii_tx_en = (r_q.state == ST_PRE) || (r_q.state == ST_DATA) ||
                    (r_q.state == ST_PAD) || (r_q.state == ST_FCS);
        mii_txd   = mii_tx_en ? (r_q.nib ? r_q.oct[7:4] : r_q.oct[3:0]) : 4'h0;
    end

endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mii_tx_en,
    input logic [3:0] mii_txd,
    input logic       app_ready
);

    // R11
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!mii_tx_en && !app_ready);
        end
    end

    // R1
    idle_txd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mii_tx_en |-> (mii_txd == 4'h0));

    // R1
    frame_opens_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (mii_txd == 4'h5));

    // R12
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_ready |=> !app_ready);

    // R12
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_ready |-> mii_tx_en);

    // R6
    gap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mii_tx_en) |=> !mii_tx_en);

endmodule

bind mii_tx_framer mii_tx_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mii_tx_en (mii_tx_en),
    .mii_txd   (mii_txd),
    .app_ready (app_ready)
);

// File: tb/sim_mii_tx_framer.sv
module sim_mii_tx_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        app_valid = 1'b0;
    logic [7:0]  app_data = 8'h00;
    logic        app_sof = 1'b0;
    logic        app_eof = 1'b0;
    logic        app_pad_en = 1'b0;
    logic        app_crc_en = 1'b0;
    logic        app_ready;
    logic        full_duplex = 1'b1;
    logic        fc_req = 1'b0;
    logic [15:0] pause_time = 16'h1234;
    logic [47:0] station_mac = 48'h02_11_22_33_44_55;
    logic [2:0]  ifg_sel = 3'd0;
    logic [3:0]  mii_txd;
    logic        mii_tx_en;

    int n_run = 0;
    int n_fail = 0;
    int got_gap = 0;
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];

    // {len, seed, pad, crc, ifg_sel}
    localparam int NVEC = 7;
    localparam logic [20:0] VEC [NVEC] = '{
        {8'd1,  8'h11, 1'b1, 1'b1, 3'd0},
        {8'd64, 8'hA0, 1'b1, 1'b1, 3'd7},
        {8'd59, 8'h3C, 1'b1, 1'b1, 3'd3},
        {8'd60, 8'h5A, 1'b1, 1'b1, 3'd1},
        {8'd10, 8'h77, 1'b0, 1'b1, 3'd5},
        {8'd20, 8'hC3, 1'b0, 1'b0, 3'd2},
        {8'd12, 8'h01, 1'b1, 1'b0, 3'd4}
    };

    always #10 clk = ~clk;

    mii_tx_framer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .app_valid   (app_valid),
        .app_data    (app_data),
        .app_sof     (app_sof),
        .app_eof     (app_eof),
        .app_pad_en  (app_pad_en),
        .app_crc_en  (app_crc_en),
        .app_ready   (app_ready),
        .full_duplex (full_duplex),
        .fc_req      (fc_req),
        .pause_time  (pause_time),
        .station_mac (station_mac),
        .ifg_sel     (ifg_sel),
        .mii_txd     (mii_txd),
        .mii_tx_en   (mii_tx_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_frame(input bit pad, input bit crc);
        logic [31:0] c;
        if (pad) begin
            while (exp_q.size() - 8 < 60) exp_q.push_back(8'h00);
        end
        if (crc) begin
            c = 32'hFFFF_FFFF;
            for (int k = 8; k < exp_q.size(); k++) begin
                c = c ^ {24'h0, exp_q[k]};
                for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
            c = ~c;
            for (int k = 0; k < 4; k++) exp_q.push_back(c[8*k +: 8]);
        end
    endtask

    task automatic start_exp();
        exp_q.delete();
        for (int k = 0; k < 7; k++) exp_q.push_back(8'h55);
        exp_q.push_back(8'hD5);
    endtask

    task automatic build_app(input int len, input logic [7:0] seed, input bit pad, input bit crc);
        start_exp();
        for (int k = 0; k < len; k++) exp_q.push_back(seed + 8'(k * 7));
        finish_frame(pad, crc);
    endtask

    task automatic build_pause(input logic [15:0] q);
        start_exp();
        exp_q.push_back(8'h01); exp_q.push_back(8'h80); exp_q.push_back(8'hC2);
        exp_q.push_back(8'h00); exp_q.push_back(8'h00); exp_q.push_back(8'h01);
        for (int k = 5; k >= 0; k--) exp_q.push_back(station_mac[8*k +: 8]);
        exp_q.push_back(8'h88); exp_q.push_back(8'h08);
        exp_q.push_back(8'h00); exp_q.push_back(8'h01);
        exp_q.push_back(q[15:8]); exp_q.push_back(q[7:0]);
        finish_frame(1'b1, 1'b1);
    endtask

    // called at a falling edge
    task automatic grab_frame();
        logic [3:0] lo;
        got_gap = 0;
        while (!mii_tx_en) begin
            got_gap++;
            @(negedge clk);
        end
        got_q.delete();
        while (mii_tx_en) begin
            lo = mii_txd;
            @(negedge clk);
            got_q.push_back({mii_txd, lo});
            @(negedge clk);
        end
    endtask

    task automatic compare(input string req, input string what);
        int bad;
        bad = -1;
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++) begin
            if (bad < 0 && got_q[k] != exp_q[k]) bad = k;
        end
        if (got_q.size() != exp_q.size()) begin
            check(1'b0, req, {what, " octet count"}, got_q.size(), exp_q.size());
        end else if (bad >= 0) begin
            $display("  mismatch at octet %0d", bad);
            check(1'b0, req, {what, " octet value"}, got_q[bad], exp_q[bad]);
        end else begin
            check(1'b1, req, what, 0, 0);
        end
    endtask

    // called at a falling edge
    task automatic drive_frame(input int len, input logic [7:0] seed, input bit pad, input bit crc);
        for (int k = 0; k < len; k++) begin
            app_valid  = 1'b1;
            app_sof    = (k == 0);
            app_eof    = (k == len - 1);
            app_data   = seed + 8'(k * 7);
            app_pad_en = pad;
            app_crc_en = crc;
            while (!app_ready) @(negedge clk);
            @(negedge clk);
        end
        app_valid = 1'b0;
        app_sof   = 1'b0;
        app_eof   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seen;
        // reset state, R11
        repeat (3) @(negedge clk);
        check(mii_tx_en == 1'b0, "R11", "tx_en in reset", mii_tx_en, 0);
        check(mii_txd == 4'h0, "R11", "txd in reset", mii_txd, 0);
        check(app_ready == 1'b0, "R11", "ready in reset", app_ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // vector table: R1 R2 R3 R4 R5 R6
        fork
            begin
                for (int i = 0; i < NVEC; i++) begin
                    ifg_sel = VEC[i][2:0];
                    drive_frame(int'(VEC[i][20:13]), VEC[i][12:5], VEC[i][4], VEC[i][3]);
                end
            end
            begin
                for (int i = 0; i < NVEC; i++) begin
                    grab_frame();
                    build_app(int'(VEC[i][20:13]), VEC[i][12:5], VEC[i][4], VEC[i][3]);
                    compare("R1 R2 R3 R4 R5", $sformatf("table frame %0d", i));
                    if (i > 0) begin
                        check(got_gap == 10 + 2 * int'(VEC[i][2:0]), "R6",
                              $sformatf("gap before frame %0d", i),
                              got_gap, 10 + 2 * int'(VEC[i][2:0]));
                    end
                end
            end
        join

        repeat (40) @(negedge clk);
        check(app_ready == 1'b0 && mii_tx_en == 1'b0, "R12", "ready while idle", app_ready, 0);

        // pause insertion: R7 R9 R6
        ifg_sel = 3'd2;
        fork
            begin
                drive_frame(30, 8'h40, 1'b1, 1'b1);
                drive_frame(16, 8'h90, 1'b1, 1'b1);
            end
            begin
                repeat (20) @(negedge clk);
                fc_req = 1'b1;
            end
            begin
                grab_frame();
                build_app(30, 8'h40, 1'b1, 1'b1);
                compare("R9", "frame ahead of pause");
                grab_frame();
                build_pause(16'h1234);
                compare("R7", "pause on rising request");
                check(got_gap == 14, "R6", "gap before pause", got_gap, 14);
                grab_frame();
                build_app(16, 8'h90, 1'b1, 1'b1);
                compare("R9", "waiting frame after pause");
                check(got_gap == 14, "R9", "gap after pause", got_gap, 14);
            end
        join

        // release: R8
        repeat (5) @(negedge clk);
        fc_req = 1'b0;
        grab_frame();
        build_pause(16'h0000);
        compare("R8", "zero pause on release");

        // half duplex: R10
        repeat (40) @(negedge clk);
        full_duplex = 1'b0;
        seen = 0;
        repeat (5) @(negedge clk);
        fc_req = 1'b1;
        repeat (100) begin @(negedge clk); if (mii_tx_en) seen++; end
        fc_req = 1'b0;
        repeat (300) begin @(negedge clk); if (mii_tx_en) seen++; end
        check(seen == 0, "R10", "tx cycles in half duplex", seen, 0);
        full_duplex = 1'b1;
        seen = 0;
        repeat (200) begin @(negedge clk); if (mii_tx_en) seen++; end
        check(seen == 0, "R10", "tx cycles after return to full duplex", seen, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule